// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This block controls clocking and reset for a small 8-bit microcontroller. It runs from the oscillator clock. A free-running divider turns that clock into an internal tick and a machine-cycle strobe. When an external clock source is selected, a toggle stage halves the rate first. From the tick it derives three enables: one for the core clock, one for the peripheral clock and one for the oscillator. The gated clocks are represented by enables that a clock-gating cell downstream consumes.

The core requests two low-power states by writing request pulses for the idle and power-down bits. In idle, the core clock stops while the peripherals keep running. Idle ends when an interrupt is pending; the interrupt input is already qualified by its enable. Idle also ends on a valid reset. In power-down, the oscillator enable drops and only a valid reset brings the device back.

The external reset pin is active high. It is synchronised by two flip-flops and must stay high for a minimum number of machine cycles to be accepted. While the internal reset is active, load controls drive the ports to all-ones and set the register file to its start values. The stack pointer starts at 07h, every other register starts at 00h, and the serial data buffer keeps its contents.

Top module: `pwr_rst_seq`

## Requirements
- R1: With `ext_clk_sel`=0 the internal tick is active every clock. `mc_stb` is high for one clock every MC_DIV ticks, which is every 12 clocks by default.
- R2: With `ext_clk_sel`=1 a toggle stage lets only every second clock become a tick. `mc_stb` then comes every 2*MC_DIV clocks, which is every 24 by default.
- R3: A reset pin pulse that stays high for at least MC_DIV*RST_MC ticks (24) asserts `int_rst`. A pulse of 23 or fewer ticks leaves `int_rst` low.
- R4: `por_n` low asserts `int_rst` at once. Once the pin is low again, `int_rst` falls only on the clock edge that ends a machine cycle, which is the edge where `mc_stb` was high.
- R5: An `idle_req` pulse sets `idle_flag`. While it is set, `core_clk_en` stays 0, while `periph_clk_en` and `mc_stb` keep running.
- R6: While idle, a high `irq_pending` clears `idle_flag` on the edge that ends the current machine cycle, and `core_clk_en` resumes.
- R7: A `pd_req` pulse sets `pd_flag`. While it is set and the reset pin is low, `osc_en`, `core_clk_en`, `periph_clk_en` and `mc_stb` are all 0.
- R8: In power-down, `irq_pending` and reset pulses that are too short leave `pd_flag` set. Only an accepted reset clears it.
- R9: When `idle_req` and `pd_req` arrive in the same cycle, the block enters power-down and `idle_flag` stays 0.
- R10: While `int_rst` is high, the following hold:
  - `port_init_en`=1 and `port_init_data` is all ones.
  - `sfr_init_en` has a 1 for every register index except SBUF_IDX (default 6).
  - In `sfr_init_data`, byte i occupies bits 8i+7:8i. Byte SP_IDX (default 1) is 07h and every other byte is 00h.
  - When `int_rst` is low, every load enable is 0.
- R11: Idle and power-down requests that arrive while `int_rst` is high are ignored, and the block leaves reset in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_clk_sel | input | 1 | 1 = external clock source, which adds the divide-by-two stage |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| irq_pending | input | 1 | An enabled interrupt is pending |
| idle_req | input | 1 | One-cycle write of the idle bit |
| pd_req | input | 1 | One-cycle write of the power-down bit |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable (one tick) |
| periph_clk_en | output | 1 | Peripheral clock enable (one tick) |
| mc_stb | output | 1 | Strobe on the last tick of each machine cycle |
| int_rst | output | 1 | Synchronous internal reset, active high |
| idle_flag | output | 1 | Idle state bit |
| pd_flag | output | 1 | Power-down state bit |
| port_init_en | output | 1 | Load port latches with their reset value |
| port_init_data | output | PORT_W | Port reset value |
| sfr_init_en | output | NUM_SFR | Per-register load enable |
| sfr_init_data | output | 8*NUM_SFR | Per-register reset values, packed by index |

## Verification
The bench builds the block with its default parameters: a 12-tick machine cycle, a two-cycle minimum reset width, eight registers with the stack pointer at index 1 and the buffer at index 6, and a 32-bit port. With these values, reset pulses of 23 and 24 ticks sit exactly on both sides of the acceptance limit. Both clock-source settings fit in short strobe-spacing measurements. Every load-enable and load-value bit can be compared one for one against values the bench computes itself.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SP_START  = 8'h07;
  localparam logic [BYTE_W-1:0] REG_START = 8'h00;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
  parameter int MC_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic ext_sel,
  output logic tick,
  output logic mc_stb
);
  localparam int CW = $clog2(MC_DIV);
  localparam logic [CW-1:0] LAST = CW'(MC_DIV - 1);

  logic          half_q, half_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // the toggle stage only gates ticks when the external source is chosen
  assign tick   = osc_en & (~ext_sel | half_q);
  assign mc_stb = tick & (cnt_q == LAST);

  always_comb begin
    half_d = half_q;
    if (osc_en) half_d = ~half_q;
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
  parameter int MC_DIV = 12,
  parameter int RST_MC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic tick,
  input  logic mc_stb,
  output logic rst_s,
  output logic accept,
  output logic int_rst
);
  localparam int MIN_TICKS = MC_DIV * RST_MC;
  localparam int WW = $clog2(MIN_TICKS + 1);
  localparam logic [WW-1:0] W_LAST = WW'(MIN_TICKS - 1);
  localparam logic [WW-1:0] W_SAT  = WW'(MIN_TICKS);

  logic          meta_q, sync_q;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          irst_q, irst_d;

  assign rst_s   = sync_q;
  assign accept  = sync_q & tick & (wcnt_q == W_LAST);
  assign int_rst = irst_q;

  always_comb begin
    wcnt_d = wcnt_q;
    if (!sync_q)                    wcnt_d = '0;
    else if (tick && wcnt_q != W_SAT) wcnt_d = wcnt_q + 1'b1;

    irst_d = irst_q;
    if (accept)                          irst_d = 1'b1;
    else if (irst_q && !sync_q && mc_stb) irst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      wcnt_q <= '0;
      irst_q <= 1'b1;
    end else begin
      meta_q <= rst_pin;
      sync_q <= meta_q;
      wcnt_q <= wcnt_d;
      irst_q <= irst_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic int_rst,
  input  logic accept,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pending,
  input  logic mc_stb,
  output logic idle_flag,
  output logic pd_flag
);
  pm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (accept || int_rst) begin
      st_d = PM_RUN;
    end else begin
      unique case (st_q)
        PM_RUN: begin
          if (pd_req)        st_d = PM_DOWN;
          else if (idle_req) st_d = PM_IDLE;
        end
        PM_IDLE: begin
          if (pd_req)                    st_d = PM_DOWN;
          else if (irq_pending && mc_stb) st_d = PM_RUN;
        end
        PM_DOWN: st_d = PM_DOWN;
        default: st_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PM_RUN;
    else        st_q <= st_d;
  end

  assign idle_flag = (st_q == PM_IDLE);
  assign pd_flag   = (st_q == PM_DOWN);
endmodule

// File: rtl/pwr_init_map.sv
module pwr_init_map
  import pwr_rst_pkg::*;
#(
  parameter int NUM_SFR  = 8,
  parameter int SP_IDX   = 1,
  parameter int SBUF_IDX = 6,
  parameter int PORT_W   = 32
) (
  input  logic                      int_rst,
  output logic                      port_init_en,
  output logic [PORT_W-1:0]         port_init_data,
  output logic [NUM_SFR-1:0]        sfr_init_en,
  output logic [NUM_SFR*BYTE_W-1:0] sfr_init_data
);
  assign port_init_en   = int_rst;
  assign port_init_data = '1;

  for (genvar i = 0; i < NUM_SFR; i++) begin : g_sfr
    if (i == SBUF_IDX) begin : g_keep
      assign sfr_init_en[i] = 1'b0;
    end else begin : g_load
      assign sfr_init_en[i] = int_rst;
    end
    if (i == SP_IDX) begin : g_sp
      assign sfr_init_data[i*BYTE_W +: BYTE_W] = SP_START;
    end else begin : g_zero
      assign sfr_init_data[i*BYTE_W +: BYTE_W] = REG_START;
    end
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int MC_DIV   = 12,
  parameter int RST_MC   = 2,
  parameter int NUM_SFR  = 8,
  parameter int SP_IDX   = 1,
  parameter int SBUF_IDX = 6,
  parameter int PORT_W   = 32
) (
  input  logic                      osc_clk,
  input  logic                      por_n,
  input  logic                      ext_clk_sel,
  input  logic                      rst_pin,
  input  logic                      irq_pending,
  input  logic                      idle_req,
  input  logic                      pd_req,
  output logic                      osc_en,
  output logic                      core_clk_en,
  output logic                      periph_clk_en,
  output logic                      mc_stb,
  output logic                      int_rst,
  output logic                      idle_flag,
  output logic                      pd_flag,
  output logic                      port_init_en,
  output logic [PORT_W-1:0]         port_init_data,
  output logic [NUM_SFR-1:0]        sfr_init_en,
  output logic [NUM_SFR*BYTE_W-1:0] sfr_init_data
);
  logic tick;
  logic rst_s;
  logic accept;

  // a reset pin held during power-down restarts the oscillator so it can be timed
  assign osc_en        = ~pd_flag | rst_s;
  assign core_clk_en   = tick & ~idle_flag & ~pd_flag;
  assign periph_clk_en = tick & ~pd_flag;

  pwr_clk_div #(.MC_DIV(MC_DIV)) u_div (
    .clk    (osc_clk),
    .rst_n  (por_n),
    .osc_en (osc_en),
    .ext_sel(ext_clk_sel),
    .tick   (tick),
    .mc_stb (mc_stb)
  );

  pwr_rst_filter #(.MC_DIV(MC_DIV), .RST_MC(RST_MC)) u_filt (
    .clk    (osc_clk),
    .rst_n  (por_n),
    .rst_pin(rst_pin),
    .tick   (tick),
    .mc_stb (mc_stb),
    .rst_s  (rst_s),
    .accept (accept),
    .int_rst(int_rst)
  );

  pwr_mode_ctl u_mode (
    .clk        (osc_clk),
    .rst_n      (por_n),
    .int_rst    (int_rst),
    .accept     (accept),
    .idle_req   (idle_req),
    .pd_req     (pd_req),
    .irq_pending(irq_pending),
    .mc_stb     (mc_stb),
    .idle_flag  (idle_flag),
    .pd_flag    (pd_flag)
  );

  pwr_init_map #(
    .NUM_SFR (NUM_SFR),
    .SP_IDX  (SP_IDX),
    .SBUF_IDX(SBUF_IDX),
    .PORT_W  (PORT_W)
  ) u_map (
    .int_rst       (int_rst),
    .port_init_en  (port_init_en),
    .port_init_data(port_init_data),
    .sfr_init_en   (sfr_init_en),
    .sfr_init_data (sfr_init_data)
  );
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
  parameter int MC_DIV  = 12,
  parameter int NUM_SFR = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               mc_stb,
  input logic               int_rst,
  input logic               accept,
  input logic               rst_s,
  input logic               osc_en,
  input logic               core_clk_en,
  input logic               idle_flag,
  input logic               pd_flag,
  input logic               idle_req,
  input logic               pd_req,
  input logic               port_init_en,
  input logic [NUM_SFR-1:0] sfr_init_en
);
  localparam int CW = $clog2(MC_DIV);
  logic [CW-1:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tcnt_q <= '0;
    else if (mc_stb) tcnt_q <= '0;
    else if (tick)   tcnt_q <= tcnt_q + 1'b1;
  end

  p_mc_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb |-> (tcnt_q == CW'(MC_DIV - 1)));

  p_rst_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> $past(mc_stb));

  p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> !core_clk_en);

  p_wake_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_flag) |-> (int_rst || pd_flag || $past(mc_stb)));

  p_pd_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_flag && !rst_s) |-> !osc_en);

  p_pd_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_flag) |-> int_rst);

  p_pd_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && pd_req && !int_rst && !accept) |=> (pd_flag && !idle_flag));

  p_init_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|sfr_init_en) |-> (int_rst && port_init_en));

  p_req_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> (!idle_flag && !pd_flag));
endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(.MC_DIV(MC_DIV), .NUM_SFR(NUM_SFR)) u_chk (
  .clk         (osc_clk),
  .rst_n       (por_n),
  .tick        (tick),
  .mc_stb      (mc_stb),
  .int_rst     (int_rst),
  .accept      (accept),
  .rst_s       (rst_s),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .idle_flag   (idle_flag),
  .pd_flag     (pd_flag),
  .idle_req    (idle_req),
  .pd_req      (pd_req),
  .port_init_en(port_init_en),
  .sfr_init_en (sfr_init_en)
);

// File: tb/pwr_rst_seq_bench.sv
`timescale 1ns/1ps
module pwr_rst_seq_bench;
  localparam int NS = 8;
  localparam int PW = 32;
  localparam int SPI = 1;
  localparam int SBI = 6;

  logic osc_clk = 1'b0;
  logic por_n, ext_clk_sel, rst_pin, irq_pending, idle_req, pd_req;
  logic osc_en, core_clk_en, periph_clk_en, mc_stb, int_rst, idle_flag, pd_flag;
  logic port_init_en;
  logic [PW-1:0] port_init_data;
  logic [NS-1:0] sfr_init_en;
  logic [NS*8-1:0] sfr_init_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit win_done = 0;
  bit seen_rise = 0;
  bit exp_q[$];

  always #10 osc_clk = ~osc_clk;

  pwr_rst_seq u_pwr_rst_seq (
    .osc_clk(osc_clk), .por_n(por_n), .ext_clk_sel(ext_clk_sel), .rst_pin(rst_pin),
    .irq_pending(irq_pending), .idle_req(idle_req), .pd_req(pd_req),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .mc_stb(mc_stb), .int_rst(int_rst), .idle_flag(idle_flag), .pd_flag(pd_flag),
    .port_init_en(port_init_en), .port_init_data(port_init_data),
    .sfr_init_en(sfr_init_en), .sfr_init_data(sfr_init_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge osc_clk);
  endtask

  // driver: one reset-pin pulse of len cycles, expected outcome queued
  task automatic pulse_rst(int len, bit expect_acc);
    exp_q.push_back(expect_acc);
    rst_pin = 1'b1;
    wait_n(len);
    rst_pin = 1'b0;
    wait_n(40);
    win_done = 1'b1;
    wait_n(1);
  endtask

  task automatic strobe_gap(output int gap);
    int k;
    gap = -1;
    for (int i = 0; i < 60 && !mc_stb; i++) @(negedge osc_clk);
    @(negedge osc_clk);
    k = 1;
    while (!mc_stb && k < 60) begin
      @(negedge osc_clk);
      k++;
    end
    gap = k;
  endtask

  // monitor: reset acceptance scoreboard and release alignment (R3, R4)
  initial begin
    bit prev_rst;
    bit prev_stb;
    prev_rst = 1'b1;
    prev_stb = 1'b0;
    forever begin
      @(negedge osc_clk);
      #1;
      if (por_n) begin
        if (int_rst && !prev_rst) seen_rise = 1'b1;
        if (!int_rst && prev_rst) chk("R4 release after strobe", 64'(prev_stb), 64'd1);
      end
      prev_rst = int_rst;
      prev_stb = mc_stb;
      if (win_done) begin
        if (exp_q.size() == 0) chk("R3 scoreboard underflow", 64'd1, 64'd0);
        else chk("R3 reset acceptance", 64'(seen_rise), 64'(exp_q.pop_front()));
        seen_rise = 1'b0;
        win_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge osc_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int gap;
    bit seen;
    bit prev_stb;
    logic [NS-1:0] exp_en;
    logic [NS*8-1:0] exp_dat;
    por_n = 1'b0; ext_clk_sel = 1'b0; rst_pin = 1'b0;
    irq_pending = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
    wait_n(3);
    // reset state
    chk("R4 int_rst during por", 64'(int_rst), 64'd1);
    chk("R7 osc_en at reset", 64'(osc_en), 64'd1);
    chk("R5 idle_flag at reset", 64'(idle_flag), 64'd0);
    chk("R10 port_init_en in reset", 64'(port_init_en), 64'd1);
    chk("R10 port_init_data", 64'(port_init_data), 64'hFFFF_FFFF);
    for (int i = 0; i < NS; i++) begin
      exp_en[i] = (i != SBI);
      exp_dat[i*8 +: 8] = (i == SPI) ? 8'h07 : 8'h00;
    end
    chk("R10 sfr_init_en", 64'(sfr_init_en), 64'(exp_en));
    chk("R10 sfr_init_data", 64'(sfr_init_data), 64'(exp_dat));
    por_n = 1'b1;
    wait_n(20);
    chk("R4 released after por", 64'(int_rst), 64'd0);
    chk("R10 enables off out of reset", 64'({sfr_init_en, port_init_en}), 64'd0);

    // R1 / R2 strobe spacing
    strobe_gap(gap);
    chk("R1 strobe spacing crystal", 64'(gap), 64'd12);
    ext_clk_sel = 1'b1;
    strobe_gap(gap);
    strobe_gap(gap);
    chk("R2 strobe spacing external", 64'(gap), 64'd24);
    ext_clk_sel = 1'b0;
    strobe_gap(gap);

    // R3 width filter around the limit
    pulse_rst(23, 1'b0);
    pulse_rst(24, 1'b1);
    pulse_rst(5, 1'b0);
    pulse_rst(40, 1'b1);

    // R5 idle
    idle_req = 1'b1; wait_n(1); idle_req = 1'b0; wait_n(1);
    chk("R5 idle_flag set", 64'(idle_flag), 64'd1);
    seen = 1'b0; gap = 0;
    for (int i = 0; i < 30; i++) begin
      if (core_clk_en) seen = 1'b1;
      if (periph_clk_en) gap++;
      wait_n(1);
    end
    chk("R5 core clock stopped", 64'(seen), 64'd0);
    chk("R5 periph clock runs", 64'(gap), 64'd30);

    // R6 interrupt wake on machine-cycle boundary
    irq_pending = 1'b1;
    prev_stb = 1'b0; gap = 0;
    while (idle_flag && gap < 30) begin
      prev_stb = mc_stb;
      wait_n(1);
      gap++;
    end
    chk("R6 idle cleared", 64'(idle_flag), 64'd0);
    chk("R6 wake at strobe", 64'(prev_stb), 64'd1);
    chk("R6 core clock resumes", 64'(core_clk_en), 64'd1);
    irq_pending = 1'b0;
    wait_n(5);

    // R7 power-down
    pd_req = 1'b1; wait_n(1); pd_req = 1'b0; wait_n(1);
    chk("R7 pd_flag set", 64'(pd_flag), 64'd1);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (osc_en || core_clk_en || periph_clk_en || mc_stb) seen = 1'b1;
      wait_n(1);
    end
    chk("R7 everything stopped", 64'(seen), 64'd0);

    // R8 no interrupt exit, short reset rejected, long reset accepted
    irq_pending = 1'b1;
    wait_n(40);
    chk("R8 irq ignored in pd", 64'(pd_flag), 64'd1);
    irq_pending = 1'b0;
    pulse_rst(10, 1'b0);
    chk("R8 short reset keeps pd", 64'(pd_flag), 64'd1);
    pulse_rst(30, 1'b1);
    chk("R8 reset exits pd", 64'(pd_flag), 64'd0);
    chk("R8 oscillator back", 64'(osc_en), 64'd1);

    // R9 both requests together
    idle_req = 1'b1; pd_req = 1'b1; wait_n(1);
    idle_req = 1'b0; pd_req = 1'b0; wait_n(1);
    chk("R9 pd wins", 64'({pd_flag, idle_flag}), 64'b10);
    pulse_rst(30, 1'b1);

    // R11 requests during reset are ignored
    exp_q.push_back(1'b1);
    rst_pin = 1'b1;
    wait_n(35);
    chk("R11 int_rst held", 64'(int_rst), 64'd1);
    idle_req = 1'b1; pd_req = 1'b1; wait_n(1);
    idle_req = 1'b0; pd_req = 1'b0; wait_n(2);
    chk("R11 requests ignored", 64'({pd_flag, idle_flag}), 64'd0);
    chk("R10 sfr_init_en on pin reset", 64'(sfr_init_en), 64'(exp_en));
    rst_pin = 1'b0;
    wait_n(40);
    win_done = 1'b1;
    wait_n(2);
    chk("R11 run state after reset", 64'({pd_flag, idle_flag, int_rst}), 64'd0);
    chk("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule